// File: doc/BRIEF.md
# Debug Port Pushed Transfer Engine

This block sits between a debug-port front end and an access-port bus. The front end sends single read or write requests. The engine either forwards each request to the access port or, for writes in one of the two pushed modes, keeps the write data, reads the target address instead and compares the returned word against the kept data, one byte lane at a time under a lane mask. The outcome of that comparison can raise a sticky compare flag. In verify sense the flag is raised on a difference; in compare sense it is raised on equality.

A second sticky flag records overruns, which are requests that arrive while an earlier one is still in flight, provided overrun detection is switched on. While either sticky flag is set, new requests are refused with an error response and never reach the access port. Software clears the flags through a small control register and an abort register. A static configuration input decides whether the overrun flag can be cleared by writing 1 to it in the control register, or only through the abort register.

The access-port side is a single-outstanding master: a request is held until the port acknowledges it, and the acknowledge cycle also carries read data.

Top module: `dp_push_engine`

## Requirements
- R1: After reset the control register reads 0, no access-port request is pending and no front-end response is given.
- R2: The control register layout is: bits [1:0] transfer mode (0 normal, 1 pushed-verify, 2 pushed-compare, 3 reserved), bit 2 overrun-detect enable, bit 3 overrun flag, bit 4 compare flag, bits [8:5] byte-lane mask (bit 5 = lane 0 = data bits [7:0]). A control write loads mode, enable and mask, and the register reads back these fields.
- R3: In normal mode an accepted request appears on the access port in the cycle after acceptance, with the same direction, address and write data. It is held until acknowledged. Exactly one response follows in the cycle after the acknowledge, and for a read it carries the acknowledged read data.
- R4: A read request is always forwarded as a plain read, whatever the transfer mode.
- R5: In pushed-verify mode a write is issued as a read of the same address. The target is not written, and the compare flag is set if any enabled lane differs from the kept write data.
- R6: In pushed-compare mode a write is issued as a read of the same address, and the compare flag is set if every enabled lane equals the kept write data.
- R7: Only lanes whose mask bit is 1 take part in the comparison. A mask of 0 counts as equal. Mode and mask are taken when the request is accepted.
- R8: Transfer mode 3 behaves exactly like normal mode: the write is forwarded and no comparison is made.
- R9: The compare flag stays set until cleared, either by a control write with bit 4 = 1 or by an abort write with bit 0 = 1. Later comparisons never clear it.
- R10: A request arriving while a transfer is in flight is discarded: it gets no response and no access. If detection is enabled it sets the overrun flag; if detection is disabled it leaves the flag clear.
- R11: While either sticky flag is set, a request gets an error response in the next cycle and causes no access-port activity.
- R12: An abort write with bit 1 = 1 clears the overrun flag. A control write with bit 3 = 1 also clears it when `cfg_orun_w1c` is 1, and leaves it unchanged when `cfg_orun_w1c` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_orun_w1c | input | 1 | 1: overrun flag clearable by control write-1; 0: abort-only |
| csr_wen | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0: control register, 1: abort register |
| csr_wdata | input | 9 | Register write data |
| csr_rdata | output | 9 | Control register contents |
| req_valid | input | 1 | Front-end request strobe |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Request write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response is a refusal |
| rsp_rdata | output | 32 | Read data of the response (0 for writes) |
| ap_req | output | 1 | Access-port request, held until acknowledged |
| ap_write | output | 1 | Access-port direction |
| ap_addr | output | 32 | Access-port address |
| ap_wdata | output | 32 | Access-port write data |
| ap_ack | input | 1 | Access-port acknowledge |
| ap_rdata | input | 32 | Access-port read data, valid with acknowledge |

## Verification
The assertions assume that the access port raises `ap_ack` only while `ap_req` is high, and for only one cycle per transfer. They also assume that `cfg_orun_w1c` changes only while no transfer is in flight. The bench's access-port responder therefore acknowledges only a pending request, after a programmable wait. It drops the acknowledge in the following cycle. The bench changes the configuration input only after every response has been seen. Register writes and requests are driven on the falling edge, so every input is stable across the rising edge.

// File: rtl/push_pkg.sv
package push_pkg;

    typedef enum logic [1:0] {
        XM_NORMAL  = 2'd0,
        XM_VERIFY  = 2'd1,
        XM_COMPARE = 2'd2,
        XM_RSVD    = 2'd3
    } xfer_mode_e;

    // control register field positions
    localparam int unsigned CTL_MODE_LSB = 0;
    localparam int unsigned CTL_OEN_BIT  = 2;
    localparam int unsigned CTL_ORUN_BIT = 3;
    localparam int unsigned CTL_CMP_BIT  = 4;
    localparam int unsigned CTL_MASK_LSB = 5;

    // abort register bit positions
    localparam int unsigned ABT_CMP_BIT  = 0;
    localparam int unsigned ABT_ORUN_BIT = 1;

endpackage

// File: rtl/push_lane_cmp.sv
module push_lane_cmp #(
    parameter int unsigned DW    = 32,
    parameter int unsigned LANES = DW / 8
) (
    input  logic [DW-1:0]    got_data,
    input  logic [DW-1:0]    kept_data,
    input  logic [LANES-1:0] lane_en,
    output logic             all_equal
);
    localparam int unsigned LW = DW / LANES;

    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_ok[g] = !lane_en[g] ||
                         (got_data[g*LW +: LW] == kept_data[g*LW +: LW]);
        end
    end

    always_comb begin
        all_equal = &lane_ok;
    end

endmodule

// File: rtl/push_csr.sv
module push_csr
    import push_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned CSR_W = CTL_MASK_LSB + LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_orun_w1c,
    input  logic             csr_wen,
    input  logic             csr_sel,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             set_orun,
    input  logic             set_cmp,
    output xfer_mode_e       mode,
    output logic             orun_en,
    output logic             orun_flag,
    output logic             cmp_flag,
    output logic [LANES-1:0] lane_mask,
    output logic [CSR_W-1:0] csr_rdata
);
    typedef struct packed {
        xfer_mode_e       mode;
        logic             oen;
        logic             orun;
        logic             cmp;
        logic [LANES-1:0] mask;
    } csr_t;

    csr_t st_d, st_q;

    logic ctl_wr, abt_wr, cmp_clr, orun_clr;

    always_comb begin
        ctl_wr   = csr_wen && !csr_sel;
        abt_wr   = csr_wen && csr_sel;
        cmp_clr  = (ctl_wr && csr_wdata[CTL_CMP_BIT]) ||
                   (abt_wr && csr_wdata[ABT_CMP_BIT]);
        orun_clr = (ctl_wr && cfg_orun_w1c && csr_wdata[CTL_ORUN_BIT]) ||
                   (abt_wr && csr_wdata[ABT_ORUN_BIT]);

        st_d = st_q;
        if (ctl_wr) begin
            st_d.mode = xfer_mode_e'(csr_wdata[CTL_MODE_LSB +: 2]);
            st_d.oen  = csr_wdata[CTL_OEN_BIT];
            st_d.mask = csr_wdata[CTL_MASK_LSB +: LANES];
        end
        if (cmp_clr)  st_d.cmp  = 1'b0;
        if (orun_clr) st_d.orun = 1'b0;
        // a new event wins over a clear in the same cycle
        if (set_cmp)  st_d.cmp  = 1'b1;
        if (set_orun) st_d.orun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: XM_NORMAL, oen: 1'b0, orun: 1'b0, cmp: 1'b0,
                      mask: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mode      = st_q.mode;
        orun_en   = st_q.oen;
        orun_flag = st_q.orun;
        cmp_flag  = st_q.cmp;
        lane_mask = st_q.mask;
        csr_rdata = {st_q.mask, st_q.cmp, st_q.orun, st_q.oen, st_q.mode};
    end

    // R10
    orun_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(orun_flag) |-> $past(orun_en));

    // R9
    cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !(csr_wen && !csr_sel && csr_wdata[CTL_CMP_BIT])
                  && !(csr_wen && csr_sel && csr_wdata[ABT_CMP_BIT]))
        |=> cmp_flag);

    // R12
    orun_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (orun_flag && !cfg_orun_w1c
                   && !(csr_wen && csr_sel && csr_wdata[ABT_ORUN_BIT]))
        |=> orun_flag);

endmodule

// File: rtl/push_seq.sv
module push_seq
    import push_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfer_mode_e       mode,
    input  logic             orun_en,
    input  logic [LANES-1:0] lane_mask,
    input  logic             blocked,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata,
    output logic             ap_req,
    output logic             ap_write,
    output logic [AW-1:0]    ap_addr,
    output logic [DW-1:0]    ap_wdata,
    input  logic             ap_ack,
    input  logic [DW-1:0]    ap_rdata,
    input  logic             lanes_equal,
    output logic [DW-1:0]    kept_data,
    output logic [LANES-1:0] kept_mask,
    output logic             set_orun,
    output logic             set_cmp
);
    typedef struct packed {
        logic             busy;
        logic             write;
        logic             push;
        logic             hit_sets;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [LANES-1:0] mask;
        logic             rsp_v;
        logic             rsp_e;
        logic [DW-1:0]    rsp_d;
    } seq_t;

    seq_t sq_d, sq_q;

    logic done;

    always_comb begin
        done     = sq_q.busy && ap_ack;
        set_orun = sq_q.busy && req_valid && orun_en;
        set_cmp  = done && sq_q.push && (sq_q.hit_sets == lanes_equal);

        sq_d       = sq_q;
        sq_d.rsp_v = 1'b0;
        sq_d.rsp_e = 1'b0;

        if (sq_q.busy) begin
            if (ap_ack) begin
                sq_d.busy  = 1'b0;
                sq_d.rsp_v = 1'b1;
                sq_d.rsp_d = sq_q.write ? '0 : ap_rdata;
            end
        end else if (req_valid) begin
            if (blocked) begin
                sq_d.rsp_v = 1'b1;
                sq_d.rsp_e = 1'b1;
                sq_d.rsp_d = '0;
            end else begin
                sq_d.busy     = 1'b1;
                sq_d.write    = req_write;
                sq_d.push     = req_write &&
                                (mode == XM_VERIFY || mode == XM_COMPARE);
                sq_d.hit_sets = (mode == XM_COMPARE);
                sq_d.addr     = req_addr;
                sq_d.wdata    = req_wdata;
                sq_d.mask     = lane_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        ap_req    = sq_q.busy;
        ap_write  = sq_q.write && !sq_q.push;
        ap_addr   = sq_q.addr;
        ap_wdata  = sq_q.wdata;
        rsp_valid = sq_q.rsp_v;
        rsp_err   = sq_q.rsp_e;
        rsp_rdata = sq_q.rsp_d;
        kept_data = sq_q.wdata;
        kept_mask = sq_q.mask;
    end

    // R3
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_req && !ap_ack) |=> (ap_req && $stable(ap_addr) && $stable(ap_write)));

    // R3
    rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_req && ap_ack) |=> (rsp_valid && !rsp_err && !ap_req));

    // R11
    blocked_no_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ap_req && req_valid && blocked) |=> (!ap_req && rsp_valid && rsp_err));

    // R10
    discard_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_req && !ap_ack && req_valid) |=> (!rsp_valid && ap_req));

endmodule

// File: rtl/dp_push_engine.sv
module dp_push_engine
    import push_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned LANES = DW / 8,
    parameter int unsigned CSR_W = CTL_MASK_LSB + LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_orun_w1c,
    input  logic             csr_wen,
    input  logic             csr_sel,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata,
    output logic             ap_req,
    output logic             ap_write,
    output logic [AW-1:0]    ap_addr,
    output logic [DW-1:0]    ap_wdata,
    input  logic             ap_ack,
    input  logic [DW-1:0]    ap_rdata
);
    xfer_mode_e       mode;
    logic             orun_en, orun_flag, cmp_flag;
    logic [LANES-1:0] lane_mask, kept_mask;
    logic [DW-1:0]    kept_data;
    logic             lanes_equal, set_orun, set_cmp, blocked;

    always_comb begin
        blocked = orun_flag || cmp_flag;
    end

    push_csr #(.LANES(LANES), .CSR_W(CSR_W)) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_orun_w1c (cfg_orun_w1c),
        .csr_wen      (csr_wen),
        .csr_sel      (csr_sel),
        .csr_wdata    (csr_wdata),
        .set_orun     (set_orun),
        .set_cmp      (set_cmp),
        .mode         (mode),
        .orun_en      (orun_en),
        .orun_flag    (orun_flag),
        .cmp_flag     (cmp_flag),
        .lane_mask    (lane_mask),
        .csr_rdata    (csr_rdata)
    );

    push_seq #(.AW(AW), .DW(DW), .LANES(LANES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .orun_en     (orun_en),
        .lane_mask   (lane_mask),
        .blocked     (blocked),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata),
        .ap_req      (ap_req),
        .ap_write    (ap_write),
        .ap_addr     (ap_addr),
        .ap_wdata    (ap_wdata),
        .ap_ack      (ap_ack),
        .ap_rdata    (ap_rdata),
        .lanes_equal (lanes_equal),
        .kept_data   (kept_data),
        .kept_mask   (kept_mask),
        .set_orun    (set_orun),
        .set_cmp     (set_cmp)
    );

    push_lane_cmp #(.DW(DW), .LANES(LANES)) u_cmp (
        .got_data  (ap_rdata),
        .kept_data (kept_data),
        .lane_en   (kept_mask),
        .all_equal (lanes_equal)
    );

endmodule

// File: tb/dp_push_engine_tb.sv
`timescale 1ns/1ps
module dp_push_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_orun_w1c = 1'b0;
    logic        csr_wen = 1'b0, csr_sel = 1'b0;
    logic [8:0]  csr_wdata = '0;
    logic [8:0]  csr_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        ap_req, ap_write;
    logic [31:0] ap_addr, ap_wdata;
    logic        ap_ack = 1'b0;
    logic [31:0] ap_rdata = '0;

    always #2.5 clk = ~clk;

    dp_push_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_orun_w1c(cfg_orun_w1c),
        .csr_wen(csr_wen), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ap_req(ap_req),
        .ap_write(ap_write), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
        .ap_ack(ap_ack), .ap_rdata(ap_rdata)
    );

    int n_chk = 0, n_err = 0;
    int ap_cnt = 0, rsp_cnt = 0, err_cnt = 0;
    int lat = 1, wcnt = 0;
    logic [31:0] last_rd;
    logic [31:0] mem [16];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit         m_busy, m_write, m_push, m_sense, m_rv, m_re;
    bit         m_oen, m_o, m_c;
    bit [1:0]   m_mode;
    bit [3:0]   m_mask, m_lm;
    bit [31:0]  m_addr, m_wdata, m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_write = 0; m_push = 0; m_sense = 0; m_rv = 0; m_re = 0;
            m_oen = 0; m_o = 0; m_c = 0; m_mode = 0; m_mask = 0; m_lm = 0;
            m_addr = 0; m_wdata = 0; m_rd = 0;
        end else begin
            bit so, sc, nbusy, nrv, nre, eq;
            bit [31:0] nrd;
            so = 0; sc = 0; nbusy = m_busy; nrv = 0; nre = 0; nrd = m_rd;
            if (m_busy) begin
                if (req_valid && m_oen) so = 1;
                if (ap_ack) begin
                    nbusy = 0; nrv = 1;
                    nrd = m_write ? 32'h0 : ap_rdata;
                    if (m_push) begin
                        eq = 1;
                        for (int i = 0; i < 4; i++)
                            if (m_lm[i] && ap_rdata[8*i +: 8] != m_wdata[8*i +: 8]) eq = 0;
                        sc = m_sense ? eq : !eq;
                    end
                end
            end else if (req_valid) begin
                if (m_o || m_c) begin
                    nrv = 1; nre = 1; nrd = 0;
                end else begin
                    nbusy = 1; m_write = req_write; m_addr = req_addr;
                    m_wdata = req_wdata; m_lm = m_mask;
                    m_push = req_write && (m_mode == 1 || m_mode == 2);
                    m_sense = (m_mode == 2);
                end
            end
            if (csr_wen && !csr_sel) begin
                m_mode = csr_wdata[1:0]; m_oen = csr_wdata[2]; m_mask = csr_wdata[8:5];
                if (csr_wdata[4]) m_c = 0;
                if (cfg_orun_w1c && csr_wdata[3]) m_o = 0;
            end
            if (csr_wen && csr_sel) begin
                if (csr_wdata[0]) m_c = 0;
                if (csr_wdata[1]) m_o = 0;
            end
            if (so) m_o = 1;
            if (sc) m_c = 1;
            m_busy = nbusy; m_rv = nrv; m_re = nre; m_rd = nrd;
        end
    end

    // per-clock comparison, responder and monitor on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 ap_req", {31'b0, ap_req}, {31'b0, m_busy});
            if (m_busy) begin
                chk("R4 ap_write", {31'b0, ap_write}, {31'b0, m_write && !m_push});
                chk("R3 ap_addr", ap_addr, m_addr);
                if (ap_write) chk("R3 ap_wdata", ap_wdata, m_wdata);
            end
            chk("R3 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rv});
            if (m_rv) begin
                chk("R11 rsp_err", {31'b0, rsp_err}, {31'b0, m_re});
                chk("R3 rsp_rdata", rsp_rdata, m_rd);
            end
            chk("R2 csr_rdata", {23'b0, csr_rdata},
                {23'b0, m_mask, m_c, m_o, m_oen, m_mode});
        end
        if (rsp_valid) begin
            rsp_cnt++; last_rd = rsp_rdata;
            if (rsp_err) err_cnt++;
        end
        if (ap_req && !ap_ack) begin
            if (wcnt >= lat) begin
                ap_ack = 1'b1; wcnt = 0;
                if (ap_write) mem[ap_addr[5:2]] = ap_wdata;
                ap_rdata = ap_write ? 32'h0 : mem[ap_addr[5:2]];
            end else begin
                wcnt++;
            end
        end else begin
            ap_ack = 1'b0;
        end
    end

    always @(posedge clk) if (ap_req && ap_ack) ap_cnt++;

    // ---------------- stimulus helpers ----------------
    function automatic logic [8:0] ctl(input int md, input bit oen, input bit w1o,
                                       input bit w1c, input logic [3:0] mk);
        return {mk, w1c, w1o, oen, md[1:0]};
    endfunction

    task automatic csr_wr(input bit sel, input logic [8:0] d);
        @(negedge clk); csr_wen = 1; csr_sel = sel; csr_wdata = d;
        @(negedge clk); csr_wen = 0;
    endtask

    task automatic fe_req(input bit wr, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk); req_valid = 0;
    endtask

    task automatic settle();
        repeat (lat + 6) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int a0, r0, e0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA0000000 + i * 32'h01010101;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 csr", {23'b0, csr_rdata}, 32'h0);
        chk("R1 ap_req", {31'b0, ap_req}, 32'h0);
        chk("R1 rsp", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1;

        // R3 normal write and read
        lat = 2;
        fe_req(1, 32'h8, 32'h11223344); settle();
        chk("R3 mem write", mem[2], 32'h11223344);
        fe_req(0, 32'h8, 32'h0); settle();
        chk("R3 read data", last_rd, 32'h11223344);

        // R2 control register readback
        csr_wr(0, ctl(1, 0, 0, 0, 4'hF));
        chk("R2 ctl readback", {23'b0, csr_rdata}, 32'h1E1);

        // R4 read in verify mode is a plain read
        fe_req(0, 32'hC, 32'h0); settle();
        chk("R4 read in verify mode", last_rd, mem[3]);

        // R5 verify: equal data leaves flag clear, target unchanged
        fe_req(1, 32'h8, 32'h11223344); settle();
        chk("R5 verify equal flag", {31'b0, csr_rdata[4]}, 32'h0);
        fe_req(1, 32'h8, 32'h11223345); settle();
        chk("R5 verify diff flag", {31'b0, csr_rdata[4]}, 32'h1);
        chk("R5 target untouched", mem[2], 32'h11223344);

        // R11 blocked by compare flag
        a0 = ap_cnt; e0 = err_cnt;
        fe_req(1, 32'h4, 32'hDEAD); settle();
        chk("R11 no access", ap_cnt, a0);
        chk("R11 error response", err_cnt, e0 + 1);

        // R9 clear by control write-1, later compare does not clear
        csr_wr(0, ctl(2, 0, 0, 1, 4'h3));
        chk("R9 ctl clear", {31'b0, csr_rdata[4]}, 32'h0);

        // R6 R7 compare mode, low lanes only
        fe_req(1, 32'h8, 32'hFFFF3344); settle();
        chk("R6 R7 masked match sets", {31'b0, csr_rdata[4]}, 32'h1);
        csr_wr(1, 9'h001);
        chk("R9 abort clear", {31'b0, csr_rdata[4]}, 32'h0);
        fe_req(1, 32'h8, 32'h11223300); settle();
        chk("R6 lane diff no set", {31'b0, csr_rdata[4]}, 32'h0);

        // R7 mask zero counts as equal (verify: no set)
        csr_wr(0, ctl(1, 0, 0, 0, 4'h0));
        fe_req(1, 32'h8, 32'h0BADF00D); settle();
        chk("R7 mask zero verify", {31'b0, csr_rdata[4]}, 32'h0);
        chk("R7 mask zero no write", mem[2], 32'h11223344);

        // R8 reserved mode acts as normal
        csr_wr(0, ctl(3, 0, 0, 0, 4'hF));
        fe_req(1, 32'h10, 32'h55AA55AA); settle();
        chk("R8 reserved writes", mem[4], 32'h55AA55AA);
        chk("R8 reserved no flag", {31'b0, csr_rdata[4]}, 32'h0);

        // R10 overrun with detection, then blocked
        cfg_orun_w1c = 0; lat = 6;
        csr_wr(0, ctl(0, 1, 0, 0, 4'h0));
        a0 = ap_cnt; r0 = rsp_cnt;
        fe_req(1, 32'h14, 32'h1); @(negedge clk);
        fe_req(1, 32'h18, 32'h2); settle();
        chk("R10 flag set", {31'b0, csr_rdata[3]}, 32'h1);
        chk("R10 one access", ap_cnt, a0 + 1);
        chk("R10 one response", rsp_cnt, r0 + 1);
        chk("R10 second dropped", mem[6], 32'hA6060606);
        e0 = err_cnt;
        fe_req(0, 32'h0, 32'h0); settle();
        chk("R11 orun blocks", err_cnt, e0 + 1);

        // R12 read-only mode: control write-1 ignored, abort clears
        csr_wr(0, ctl(0, 1, 1, 0, 4'h0));
        chk("R12 ro ignore", {31'b0, csr_rdata[3]}, 32'h1);
        csr_wr(1, 9'h002);
        chk("R12 abort clears", {31'b0, csr_rdata[3]}, 32'h0);

        // R12 write-1 mode
        cfg_orun_w1c = 1;
        fe_req(1, 32'h14, 32'h3); @(negedge clk);
        fe_req(1, 32'h18, 32'h4); settle();
        chk("R12 orun again", {31'b0, csr_rdata[3]}, 32'h1);
        csr_wr(0, ctl(0, 0, 1, 0, 4'h0));
        chk("R12 w1c clears", {31'b0, csr_rdata[3]}, 32'h0);

        // R10 detection disabled: no flag, request dropped
        a0 = ap_cnt; r0 = rsp_cnt;
        fe_req(1, 32'h1C, 32'h5); @(negedge clk);
        fe_req(1, 32'h20, 32'h6); settle();
        chk("R10 disabled no flag", {31'b0, csr_rdata[3]}, 32'h0);
        chk("R10 disabled one access", ap_cnt, a0 + 1);
        chk("R10 disabled one rsp", rsp_cnt, r0 + 1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule